// File: doc/BRIEF.md
# Rotating Predicate Stage Controller

This block keeps a file of single-bit predicates that guard operations in a wide-issue pipeline. Each cycle it looks up the guard predicate of up to three operations in a bundle. For every operation it produces a registered enable. An operation whose guard reads false is turned into a no-operation. A separate read port and write port give direct access to the file.

The upper part of the file rotates. Each loop-closing branch shifts every rotating predicate up by one logical index. The freshly exposed lowest rotating predicate is then loaded with the loop-continue flag. The enable that turns on stage 1 in one iteration therefore becomes the stage-2 enable in the next. While new iterations remain, stages come on one after another. Once the flag drops, they go off one after another. This lets a single loop-body bundle serve as prolog, kernel and epilog. The rotation is a base offset added to the logical index, modulo the rotating-region size.

Top module: `rot_pred_ctrl`

## Requirements
- R1: After reset every predicate reads false except logical index 0, and the registered outputs `pr_val` and `gd_en` are 0 during reset.
- R2: Logical predicate 0 always reads true; writes to it have no effect.
- R3: A write with `pw_en` high stores `pw_val` at logical index `pw_idx`; `pr_val` returns the predicate at `pr_idx` one clock after `pr_idx` is presented.
- R4: When a write and a read name the same index in the same cycle, the read returns the value held before the write.
- R5: Operation slot i (guard index in bits [6i+5:6i] of `gd_idx`) yields `gd_en[i]` one clock later, equal to `gd_valid[i]` AND the guard predicate; an invalid slot yields 0.
- R6: Logical predicates 1 to 15 are not moved or changed by a loop branch.
- R7: On a `loop_br` cycle, logical predicate k (16 ≤ k ≤ 62) moves to logical index k+1; the old logical 63 is dropped.
- R8: On a `loop_br` cycle, logical predicate 16 is loaded with `loop_more`; over successive branches this ramps stages on while `loop_more` is 1 and off while it is 0.
- R9: The rotation base wraps modulo 48, so rotation stays correct over any number of branches, including more than 48.
- R10: A write arriving with a loop branch uses the index mapping in force before the rotation, so the written value then moves up one index with the rest. If it targets logical 63, the injected `loop_more` value overrides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pw_en | input | 1 | Predicate write enable |
| pw_idx | input | 6 | Logical index to write |
| pw_val | input | 1 | Value to write |
| pr_idx | input | 6 | Logical index to read |
| pr_val | output | 1 | Registered read data |
| gd_valid | input | 3 | Per-slot operation valid |
| gd_idx | input | 18 | Per-slot guard index, 6 bits per slot |
| gd_en | output | 3 | Registered per-slot operation enable |
| loop_br | input | 1 | Loop-closing branch strobe, rotates the file |
| loop_more | input | 1 | Loop-continue flag injected as new stage-1 predicate |

## Verification
The assertions take it for granted that every index on `pw_idx`, `pr_idx` and `gd_idx` is below 64. With the default 6-bit width this holds for any input value. They also assume that `loop_br` and the write port are the only ways to change stored state. The no-change check on the static region therefore holds only in cycles without a write. The stimulus drives full-range indices and mixes branch cycles with and without writes. It includes writes landing on index 0 and on the top rotating index during a branch. Each predicate property therefore sees both of its antecedent cases.

// File: rtl/rpred_pkg.sv
package rpred_pkg;

  // Translate a logical predicate index into a physical slot.
  // Static region passes through; rotating region is offset by base, wrapped.
  function automatic int unsigned phys_of(int unsigned lidx, int unsigned base,
                                          int unsigned n_static, int unsigned n_rot);
    int unsigned s;
    if (lidx < n_static) return lidx;
    s = lidx - n_static + base;
    if (s >= n_rot) s = s - n_rot;
    return n_static + s;
  endfunction

endpackage

// File: rtl/rpred_base.sv
module rpred_base #(
  parameter int NUM_ROT = 48,
  localparam int BASE_W = $clog2(NUM_ROT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [BASE_W-1:0] base,
  output logic [BASE_W-1:0] base_nxt
);

  always_comb begin
    if (!step)          base_nxt = base;
    else if (base == '0) base_nxt = BASE_W'(NUM_ROT - 1);
    else                base_nxt = base - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) base <= '0;
    else     base <= base_nxt;
  end

  // R9: base stays inside the rotating region
  p_base_range_r9: assert property (@(posedge clk) disable iff (rst)
    32'(base) < NUM_ROT);
  // R7: every branch moves the base, no branch leaves it alone
  p_base_moves_r7: assert property (@(posedge clk) disable iff (rst)
    step |=> base != $past(base));
  p_base_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(base));

endmodule

// File: rtl/rpred_store.sv
module rpred_store #(
  parameter int NUM_PRED   = 64,
  parameter int NUM_STATIC = 16,
  localparam int IDX_W = $clog2(NUM_PRED)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_phys,
  input  logic                wr_data,
  input  logic                inj_en,
  input  logic [IDX_W-1:0]    inj_phys,
  input  logic                inj_data,
  output logic [NUM_PRED-1:0] bits
);

  assign bits[0] = 1'b1;

  for (genvar g = 1; g < NUM_PRED; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                    bits[g] <= 1'b0;
      else if (inj_en && inj_phys == IDX_W'(g))   bits[g] <= inj_data;
      else if (wr_en && wr_phys == IDX_W'(g))     bits[g] <= wr_data;
    end
  end

  // R6: without a write, the static region is untouched by anything
  p_static_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bits[NUM_STATIC-1:0]));
  // R8: injected stage-1 bit lands where it was aimed
  p_inject_r8: assert property (@(posedge clk) disable iff (rst)
    inj_en |=> bits[$past(inj_phys)] == $past(inj_data));

endmodule

// File: rtl/rpred_rdport.sv
module rpred_rdport #(
  parameter int NUM_PRED = 64,
  localparam int IDX_W = $clog2(NUM_PRED)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [IDX_W-1:0]    phys,
  input  logic [NUM_PRED-1:0] bits,
  output logic                q
);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= en & bits[phys];
  end

  // R5: a disabled lookup always yields a cleared enable
  p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> !q);

endmodule

// File: rtl/rot_pred_ctrl.sv
module rot_pred_ctrl #(
  parameter int NUM_PRED   = 64,
  parameter int NUM_STATIC = 16,
  parameter int NUM_OPS    = 3,
  localparam int IDX_W   = $clog2(NUM_PRED),
  localparam int NUM_ROT = NUM_PRED - NUM_STATIC,
  localparam int BASE_W  = $clog2(NUM_ROT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pw_en,
  input  logic [IDX_W-1:0]         pw_idx,
  input  logic                     pw_val,
  input  logic [IDX_W-1:0]         pr_idx,
  output logic                     pr_val,
  input  logic [NUM_OPS-1:0]       gd_valid,
  input  logic [NUM_OPS*IDX_W-1:0] gd_idx,
  output logic [NUM_OPS-1:0]       gd_en,
  input  logic                     loop_br,
  input  logic                     loop_more
);
  import rpred_pkg::*;

  logic [BASE_W-1:0]   base, base_nxt;
  logic [NUM_PRED-1:0] bits;
  logic [IDX_W-1:0]    wr_phys, rd_phys, inj_phys;

  rpred_base #(.NUM_ROT(NUM_ROT)) u_base (
    .clk(clk), .rst(rst), .step(loop_br), .base(base), .base_nxt(base_nxt)
  );

  // Writes and reads use the mapping in force before this cycle's rotation.
  assign wr_phys  = IDX_W'(phys_of(32'(pw_idx), 32'(base), NUM_STATIC, NUM_ROT));
  assign rd_phys  = IDX_W'(phys_of(32'(pr_idx), 32'(base), NUM_STATIC, NUM_ROT));
  // New logical stage-1 slot under the rotated base.
  assign inj_phys = IDX_W'(NUM_STATIC + 32'(base_nxt));

  rpred_store #(.NUM_PRED(NUM_PRED), .NUM_STATIC(NUM_STATIC)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(pw_en), .wr_phys(wr_phys), .wr_data(pw_val),
    .inj_en(loop_br), .inj_phys(inj_phys), .inj_data(loop_more),
    .bits(bits)
  );

  rpred_rdport #(.NUM_PRED(NUM_PRED)) u_rd (
    .clk(clk), .rst(rst), .en(1'b1), .phys(rd_phys), .bits(bits), .q(pr_val)
  );

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic [IDX_W-1:0] op_phys;
    assign op_phys = IDX_W'(phys_of(32'(gd_idx[i*IDX_W +: IDX_W]), 32'(base),
                                    NUM_STATIC, NUM_ROT));
    rpred_rdport #(.NUM_PRED(NUM_PRED)) u_op (
      .clk(clk), .rst(rst), .en(gd_valid[i]), .phys(op_phys), .bits(bits),
      .q(gd_en[i])
    );
  end

  // R2: logical 0 reads true whatever was written
  p_zero_true_r2: assert property (@(posedge clk) disable iff (rst)
    pr_idx == '0 |=> pr_val);
  // R1: outputs are cleared while in reset
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!pr_val && gd_en == '0));

endmodule

// File: tb/sim_rot_pred_ctrl.sv
module sim_rot_pred_ctrl;
  localparam int CLK_P = 10;
  localparam int NP = 64;
  localparam int NO = 3;

  logic clk = 0, rst = 1;
  logic pw_en = 0, pw_val = 0, loop_br = 0, loop_more = 0;
  logic [5:0] pw_idx = 0, pr_idx = 0;
  logic [NO-1:0] gd_valid = 0;
  logic [NO*6-1:0] gd_idx = 0;
  logic pr_val;
  logic [NO-1:0] gd_en;

  int n_tests = 0, n_fail = 0;
  bit lp [NP];

  always #(CLK_P/2) clk = ~clk;

  rot_pred_ctrl u0 (
    .clk(clk), .rst(rst), .pw_en(pw_en), .pw_idx(pw_idx), .pw_val(pw_val),
    .pr_idx(pr_idx), .pr_val(pr_val), .gd_valid(gd_valid), .gd_idx(gd_idx),
    .gd_en(gd_en), .loop_br(loop_br), .loop_more(loop_more)
  );

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: predict from the behavioural model, advance it, compare.
  task automatic cyc(string tag);
    bit erd;
    bit [NO-1:0] een;
    erd = lp[pr_idx];
    for (int i = 0; i < NO; i++) een[i] = gd_valid[i] & lp[gd_idx[i*6 +: 6]];
    if (pw_en && pw_idx != 0) lp[pw_idx] = pw_val;
    if (loop_br) begin
      for (int k = NP-1; k > 16; k--) lp[k] = lp[k-1];
      lp[16] = loop_more;
    end
    @(posedge clk); #1;
    check(tag, {pr_val, gd_en}, {erd, een});
  endtask

  task automatic idle();
    pw_en = 0; loop_br = 0; gd_valid = 0;
  endtask

  task automatic read_all(string tag);
    idle();
    for (int k = 0; k < NP; k++) begin
      pr_idx = 6'(k);
      gd_valid = 3'b111;
      gd_idx = {6'(k), 6'((k + 1) % NP), 6'((k + 2) % NP)};
      cyc(tag);
    end
    idle();
  endtask

  task automatic branch(bit more, string tag);
    loop_br = 1; loop_more = more; cyc(tag); loop_br = 0;
  endtask

  initial begin
    for (int k = 0; k < NP; k++) lp[k] = (k == 0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {pr_val, gd_en}, 4'b0);
    rst = 0;
    read_all("R1 reset contents");

    // R2: write false to index 0
    pw_en = 1; pw_idx = 0; pw_val = 0; pr_idx = 0; cyc("R2 write p0");
    idle(); pr_idx = 0; cyc("R2 read p0");

    // R3: fill every index with a pattern, read all back
    for (int k = 1; k < NP; k++) begin
      pw_en = 1; pw_idx = 6'(k); pw_val = ((k * 7) % 3) == 0; pr_idx = 6'(k - 1);
      cyc("R3 write");
    end
    read_all("R3 readback");

    // R4: same-index write and read
    for (int k = 1; k < 20; k += 3) begin
      pw_en = 1; pw_idx = 6'(k); pw_val = ~lp[k]; pr_idx = 6'(k);
      cyc("R4 same cycle old value");
      idle(); cyc("R4 new value");
    end

    // R5: random guarded bundles, including invalid slots
    for (int n = 0; n < 200; n++) begin
      gd_valid = 3'($urandom);
      gd_idx = 18'($urandom);
      pr_idx = 6'($urandom);
      cyc("R5 guard enable");
    end
    idle();

    // R7 R8: ramp-up with continue, then drain
    for (int n = 0; n < 6; n++) branch(1, "R8 ramp up");
    read_all("R7 after ramp up");
    for (int n = 0; n < 4; n++) branch(0, "R8 drain");
    read_all("R6 R8 after drain");

    // R10: writes colliding with branches
    pw_en = 1; pw_idx = 63; pw_val = 1; loop_br = 1; loop_more = 0;
    cyc("R10 write top during branch");
    pw_en = 1; pw_idx = 20; pw_val = 1; loop_br = 1; loop_more = 1;
    cyc("R10 write mid during branch");
    pw_en = 1; pw_idx = 5; pw_val = 1; loop_br = 1; loop_more = 0;
    cyc("R10 R6 write static during branch");
    read_all("R10 readback");

    // R9: many branches past the wrap with mixed traffic
    for (int n = 0; n < 120; n++) begin
      loop_br = ($urandom % 3) != 0;
      loop_more = 1'($urandom);
      pw_en = ($urandom % 4) == 0;
      pw_idx = 6'($urandom); pw_val = 1'($urandom);
      pr_idx = 6'($urandom);
      gd_valid = 3'($urandom); gd_idx = 18'($urandom);
      cyc("R9 wrap traffic");
    end
    read_all("R9 after wrap");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule